// File: doc/BRIEF.md
# Space-Vector PWM Sector Sequencer

This block drives the three upper switches of a three-phase bridge using symmetrical space-vector modulation. Its inputs are a reference phase angle that advances over time, a modulation depth and a PWM period length in clock cycles. Its output is a three-bit leg state with one bit per half-bridge: phase A in bit 2, B in bit 1 and C in bit 0. A bit of 1 means that leg's upper switch is on.

At each period boundary the block samples all of its inputs. It finds which of six 60-degree sectors the angle lies in. It looks up the sines of the in-sector angle in a small table and splits the period among the two active vectors that bound the sector and the two null vectors.

Each period is played as seven contiguous segments: null, active, active, null, active, active, null. The null vector at the ends is the opposite of the one in the middle. The order of the two active vectors is chosen so that each step between segments switches only one leg.

Top module: `svpwm_sequencer`

## Requirements
- R1: While reset is asserted, `leg_o` is 000 and `sector_o` is 0.
- R2: The sector index is floor(6·angle/4096), where the angle is 12-bit unsigned and covers one full turn. This gives 0..5, reported on `sector_o`; index s is sector s+1. The value is taken once per period.
- R3: Sector index s uses active vectors V(s+1) and V(s+2), wrapping from V6 to V1. The encodings are V1=110, V2=010, V3=011, V4=001, V5=101 and V6=100, with bit 2 as phase A.
- R4: With `null7_first_i`=1 a period runs 111, a, b, 000, b, a, 111. With it at 0 the period runs 000, a, b, 111, b, a, 000. The first active vector a is the one that differs from the end null in a single bit.
- R5: While `null7_first_i` is held constant, the output never changes more than one bit between consecutive cycles.
- R6: Let P be the period, U = P−7, c = floor(6·angle) mod 4096, i = c>>7, and S(n) = round(4096·sin(n·60°/32)). The dwell of V(s+1) is d1 = floor(m·U·S(32−i)/2^20) and the dwell of V(s+2) is d2 = floor(m·U·S(i)/2^20). Each active segment lasts 1+floor(d/2) cycles. Let N = U − 2·floor(d1/2) − 2·floor(d2/2). Each end null lasts 1+floor(N/4) cycles and the middle null lasts 1+N−2·floor(N/4).
- R7: A depth `mag_i` above 256 (1.0 in 8 fractional bits) is treated as 256, so the active time never exceeds U.
- R8: A period setting below 8 is treated as 8. Each period lasts exactly P clock cycles.
- R9: Inputs that change during a period have no effect on that period's sector or segments. They take effect at the next period.
- R10: The first period starts on the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| angle_i | input | 12 | Reference phase angle, full turn = 4096 |
| mag_i | input | 9 | Modulation depth, 8 fractional bits |
| period_i | input | 12 | PWM period in clock cycles |
| null7_first_i | input | 1 | 1: periods start and end with 111; 0: with 000 |
| leg_o | output | 3 | Upper-switch state, bit 2 = phase A |
| sector_o | output | 3 | Latched sector index 0..5 |

## Verification
The delicate cycle is the period boundary. In that one edge the last end-null segment ends, the new sector and dwell values are latched, and the first null of the next period begins. A sector change therefore lands in the same cycle as a segment transition. The bench provokes this by sweeping the angle across every sector border, and by picking angles just either side of a border. It also changes the angle halfway through a period. Every cycle is compared with a reference schedule built from the dwell formula. The one-bit-step rule is judged across each boundary as well as inside the period.

// File: rtl/svpwm_sequencer.sv
module svpwm_sequencer #(
  parameter int ANG_W    = 12,
  parameter int MAG_W    = 9,
  parameter int MAG_FRAC = 8,
  parameter int PER_W    = 12,
  parameter int SIN_FRAC = 12,
  parameter int LUT_AW   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ANG_W-1:0] angle_i,
  input  logic [MAG_W-1:0] mag_i,
  input  logic [PER_W-1:0] period_i,
  input  logic             null7_first_i,
  output logic [2:0]       leg_o,
  output logic [2:0]       sector_o
);

  localparam int  LUT_N   = 1 << LUT_AW;
  localparam int  MIN_PER = 8;
  localparam int  ONE     = 1 << MAG_FRAC;
  localparam int  PW      = MAG_W + PER_W + SIN_FRAC + 1;
  localparam int  SHR     = MAG_FRAC + SIN_FRAC + 1;
  localparam real PI      = 3.141592653589793;

  function automatic int sin_code(input int n);
    return $rtoi($sin(real'(n) * PI / (3.0 * real'(LUT_N))) * real'(1 << SIN_FRAC) + 0.5);
  endfunction

  function automatic logic [2:0] act_vec(input logic [2:0] s);
    case (s)
      3'd0:    return 3'b110;
      3'd1:    return 3'b010;
      3'd2:    return 3'b011;
      3'd3:    return 3'b001;
      3'd4:    return 3'b101;
      default: return 3'b100;
    endcase
  endfunction

  logic [SIN_FRAC-1:0] sin_tab [LUT_N+1];
  for (genvar g = 0; g <= LUT_N; g++) begin : g_lut
    assign sin_tab[g] = SIN_FRAC'(sin_code(g));
  end

  // next-period values, from the live inputs
  logic [ANG_W+2:0]  ang6;
  logic [2:0]        sec_n, sec_nx;
  logic [LUT_AW:0]   idx;
  logic [PER_W-1:0]  per_c, u_n, h1_n, h2_n, nul_n, e_n, m_n;
  logic [MAG_W-1:0]  mag_c;
  logic [PW-1:0]     t1, t2;
  logic              fwd;

  assign ang6   = {3'b000, angle_i} * (ANG_W+3)'(6);
  assign sec_n  = ang6[ANG_W+2:ANG_W];
  assign sec_nx = (sec_n == 3'd5) ? 3'd0 : sec_n + 3'd1;
  assign idx    = {1'b0, ang6[ANG_W-1 -: LUT_AW]};
  assign per_c  = (period_i < PER_W'(MIN_PER)) ? PER_W'(MIN_PER) : period_i;
  assign u_n    = per_c - PER_W'(7);
  assign mag_c  = (mag_i > MAG_W'(ONE)) ? MAG_W'(ONE) : mag_i;
  assign t1     = PW'(mag_c) * PW'(u_n) * PW'(sin_tab[(LUT_AW+1)'(LUT_N) - idx]);
  assign t2     = PW'(mag_c) * PW'(u_n) * PW'(sin_tab[idx]);
  assign h1_n   = PER_W'(t1 >> SHR);
  assign h2_n   = PER_W'(t2 >> SHR);
  assign nul_n  = u_n - (h1_n << 1) - (h2_n << 1);
  assign e_n    = nul_n >> 2;
  assign m_n    = nul_n - (e_n << 1);
  assign fwd    = (~sec_n[0]) == null7_first_i;

  // period state
  logic             run_q, ord_q;
  logic [2:0]       seg_q, sec_q, vf_q, vs_q;
  logic [PER_W-1:0] cnt_q, le_q, lf_q, ls_q, lm_q, per_q;
  logic             bnd;
  logic [PER_W-1:0] nxt_len;

  assign bnd = !run_q || (seg_q == 3'd6 && cnt_q == PER_W'(1));

  always_comb begin
    case (seg_q)
      3'd0, 3'd4: nxt_len = lf_q;
      3'd1, 3'd3: nxt_len = ls_q;
      3'd2:       nxt_len = lm_q;
      default:    nxt_len = le_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      ord_q <= 1'b0;
      seg_q <= '0;
      sec_q <= '0;
      vf_q  <= '0;
      vs_q  <= '0;
      cnt_q <= '0;
      le_q  <= '0;
      lf_q  <= '0;
      ls_q  <= '0;
      lm_q  <= '0;
      per_q <= '0;
    end else if (bnd) begin
      run_q <= 1'b1;
      ord_q <= null7_first_i;
      seg_q <= '0;
      sec_q <= sec_n;
      vf_q  <= fwd ? act_vec(sec_n) : act_vec(sec_nx);
      vs_q  <= fwd ? act_vec(sec_nx) : act_vec(sec_n);
      lf_q  <= (fwd ? h1_n : h2_n) + PER_W'(1);
      ls_q  <= (fwd ? h2_n : h1_n) + PER_W'(1);
      le_q  <= e_n + PER_W'(1);
      lm_q  <= m_n + PER_W'(1);
      cnt_q <= e_n + PER_W'(1);
      per_q <= per_c;
    end else if (cnt_q == PER_W'(1)) begin
      seg_q <= seg_q + 3'd1;
      cnt_q <= nxt_len;
    end else begin
      cnt_q <= cnt_q - PER_W'(1);
    end
  end

  always_comb begin
    if (!run_q) leg_o = 3'b000;
    else begin
      case (seg_q)
        3'd0, 3'd6: leg_o = {3{ord_q}};
        3'd1, 3'd5: leg_o = vf_q;
        3'd2, 3'd4: leg_o = vs_q;
        default:    leg_o = {3{~ord_q}};
      endcase
    end
  end

  assign sector_o = sec_q;

  // cycles since the current period began, for the length check
  logic [PER_W-1:0] prd_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   prd_cnt <= '0;
    else if (bnd) prd_cnt <= '0;
    else          prd_cnt <= prd_cnt + PER_W'(1);
  end

  AST_GRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && $past(run_q) && $stable(ord_q) |-> $countones(leg_o ^ $past(leg_o)) <= 1); // R5
  AST_PERIOD_START: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && $past(bnd) |-> leg_o == {3{ord_q}}); // R4
  AST_SECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && !$past(bnd) |-> $stable(sector_o)); // R9
  AST_PERIOD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && bnd |-> prd_cnt == per_q - PER_W'(1)); // R8
  AST_ACTIVE_MIX: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && (seg_q == 3'd1 || seg_q == 3'd2 || seg_q == 3'd4 || seg_q == 3'd5)
    |-> ($countones(leg_o) == 1 || $countones(leg_o) == 2)); // R3

endmodule

// File: tb/svpwm_sequencer_bench.sv
module svpwm_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] angle_i = '0;
  logic [8:0]  mag_i = '0;
  logic [11:0] period_i = 12'd40;
  logic        null7_first_i = 1'b1;
  logic [2:0]  leg_o, sector_o;

  svpwm_sequencer u_svpwm_sequencer (
    .clk(clk), .rst_n(rst_n), .angle_i(angle_i), .mag_i(mag_i),
    .period_i(period_i), .null7_first_i(null7_first_i),
    .leg_o(leg_o), .sector_o(sector_o));

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  logic [2:0] prev_leg = '0;
  bit have_prev = 0;
  bit last_ord = 1;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sc(input int n);
    return $rtoi($sin(real'(n) * 3.141592653589793 / (3.0 * 32.0)) * 4096.0 + 0.5);
  endfunction

  function automatic int vtab(input int s);
    case (s)
      0: return 6; 1: return 2; 2: return 3; 3: return 1; 4: return 5; default: return 4;
    endcase
  endfunction

  // drive inputs, then sample one full period against the reference schedule
  task automatic run_period(input int ang, input int mag, input int per, input bit ord,
                            input string req, input int new_ang);
    int s, c, i, pc, u, mc, h1, h2, nul, e, md, hf, hs, vf, vs, ns, pos, half;
    longint t1, t2;
    int vecs[7];
    int lens[7];
    int sec_err, gray_err, sec_act;
    bit fwd;
    angle_i = 12'(ang); mag_i = 9'(mag); period_i = 12'(per); null7_first_i = ord;
    s   = (ang * 6) / 4096;
    c   = (ang * 6) % 4096;
    i   = c >> 7;
    pc  = (per < 8) ? 8 : per;
    u   = pc - 7;
    mc  = (mag > 256) ? 256 : mag;
    t1  = (longint'(mc) * u * sc(32 - i)) >>> 20;
    t2  = (longint'(mc) * u * sc(i)) >>> 20;
    h1  = int'(t1) / 2;
    h2  = int'(t2) / 2;
    nul = u - 2 * h1 - 2 * h2;
    e   = nul / 4;
    md  = nul - 2 * e;
    fwd = ((s % 2) == 0) == ord;
    vf  = fwd ? vtab(s) : vtab((s + 1) % 6);
    vs  = fwd ? vtab((s + 1) % 6) : vtab(s);
    hf  = fwd ? h1 : h2;
    hs  = fwd ? h2 : h1;
    ns  = ord ? 7 : 0;
    vecs = '{ns, vf, vs, 7 - ns, vs, vf, ns};
    lens = '{1 + e, 1 + hf, 1 + hs, 1 + md, 1 + hs, 1 + hf, 1 + e};
    if (ord != last_ord) have_prev = 0;
    last_ord = ord;
    pos = 0; half = pc / 2; sec_err = 0; gray_err = 0; sec_act = s;
    for (int sg = 0; sg < 7; sg++) begin
      int errs = 0;
      int av = vecs[sg];
      for (int k = 0; k < lens[sg]; k++) begin
        @(posedge clk); @(negedge clk);
        if (leg_o !== 3'(vecs[sg])) begin
          if (errs == 0) av = int'(leg_o);
          errs++;
        end
        if (sector_o !== 3'(s)) begin sec_err++; sec_act = int'(sector_o); end
        if (have_prev && $countones(leg_o ^ prev_leg) > 1) gray_err++;
        prev_leg = leg_o; have_prev = 1;
        if (pos == half && new_ang >= 0) angle_i = 12'(new_ang);
        pos++;
      end
      chk(errs == 0, req, $sformatf("segment %0d vector at angle %0d", sg, ang), av, vecs[sg]);
    end
    chk(sec_err == 0, "R2", $sformatf("sector at angle %0d", ang), sec_act, s);
    chk(gray_err == 0, "R5", "multi-leg step count", gray_err, 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(leg_o == 3'b000, "R1", "leg during reset", int'(leg_o), 0);
    chk(sector_o == 3'd0, "R1", "sector during reset", int'(sector_o), 0);
  endtask

  task automatic t_first;
    angle_i = 12'd0; mag_i = 9'd128; period_i = 12'd40; null7_first_i = 1'b1;
    rst_n = 1'b1;
    run_period(0, 128, 40, 1, "R10", -1);
  endtask

  task automatic t_sweep;
    for (int k = 0; k < 24; k++) run_period((k * 4096) / 24 + 50, 230, 64, 1, "R3", -1);
  endtask

  task automatic t_reverse;
    run_period(1500, 180, 60, 0, "R4", -1);
    run_period(2300, 180, 60, 0, "R4", -1);
    run_period(3600, 180, 60, 1, "R4", -1);
  endtask

  task automatic t_dwell;
    run_period(340, 100, 200, 1, "R6", -1);
    run_period(3900, 256, 500, 1, "R6", -1);
    run_period(2900, 37, 90, 0, "R6", -1);
  endtask

  task automatic t_clamp;
    run_period(1024, 511, 100, 1, "R7", -1);
    run_period(1024, 300, 100, 1, "R7", -1);
  endtask

  task automatic t_period_min;
    run_period(700, 0, 3, 1, "R8", -1);
    run_period(700, 200, 0, 1, "R8", -1);
  endtask

  task automatic t_border;
    run_period(682, 200, 50, 1, "R2", -1);
    run_period(683, 200, 50, 1, "R2", -1);
    run_period(4095, 200, 50, 1, "R2", -1);
  endtask

  task automatic t_latch;
    run_period(100, 200, 80, 1, "R9", 2000);
    run_period(2000, 200, 80, 1, "R9", -1);
  endtask

  initial begin
    t_reset();
    t_first();
    t_sweep();
    t_reverse();
    t_dwell();
    t_clamp();
    t_period_min();
    t_border();
    t_latch();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule